// File: doc/BRIEF.md
# ADC Capture Sequencer

This block paces the capture of converter results into groups called sequences. Software programs how many samples make up one sequence and how many sequences to take, then raises the run enable. The block arms itself and waits for an external trigger pulse. On that pulse it accepts converter results (each qualified by a valid flag) into an output buffer until the sequence is complete. A sequence total of exactly one gives single mode. Any other total gives loop mode, where the block re-arms after each sequence and waits for a fresh trigger. A zero in either count removes that limit.

Captured words leave through a first-in first-out buffer with a registered read port, meant to be drained by a transfer engine. A write into a full buffer is an overflow. The overflowing word and the next fifteen written words are thrown away as one block, after which storage resumes. Three event sources raise interrupt status: sequence complete, overflow and timeout. Timeout means the block has stalled for a programmable number of cycles, either armed without a trigger or capturing into a full buffer. Each source has its own enable. The interrupt line and the status bits are cleared by two separate pulses.

Top module: `adc_seq_capture`

## Requirements
- R1: With a sequence total of 1 (single mode), `all_done` goes high once one sequence completes, and later triggers and valid samples capture nothing until `run_en` is cycled.
- R2: A sample is accepted only while capturing and `conv_valid` is high. A sequence ends after exactly `smp_per_seq` accepted samples. `cap_strobe` is high for one cycle after each accepted sample.
- R3: With `smp_per_seq` = 0, capture goes on without end: no sequence-complete status is raised while `run_en` stays high.
- R4: In loop mode with a finite total N ≥ 2, the block re-arms after each sequence and ignores samples until the next trigger. `all_done` goes high only after the N-th sequence.
- R5: With `seq_total` = 0, sequences repeat without end and `all_done` never goes high.
- R6: Status bit 0 (sequence complete) sets at the end of every sequence, whatever the enables. `irq` rises only for a status event whose enable bit (0 = complete, 1 = overflow, 2 = timeout) is set.
- R7: A write into a full buffer sets status bit 1. That word and the next 15 written words are discarded, and later words are stored again.
- R8: Status bit 2 sets once the block has stalled for `tmo_limit` consecutive cycles, either armed without a trigger or capturing into a full buffer. A limit of 0 disables it.
- R9: A pulse on `irq_clr` drops `irq` and leaves the status bits unchanged. A pulse on `stat_clr` clears the status bits and leaves `irq` unchanged.
- R10: Dropping `run_en` at any time returns the block to idle within one cycle and restarts the sample and sequence counts from zero.
- R11: The buffer returns words in write order. `rd_data` is valid the cycle after a read while not empty, and `rd_empty` reflects the fill level.
- R12: After reset, `irq`, `irq_stat`, `busy`, `all_done` and `cap_strobe` are 0 and `rd_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low aborts and idles the block |
| trig | input | 1 | Trigger pulse starting a sequence |
| smp_per_seq | input | 16 | Samples per sequence, 0 = endless |
| seq_total | input | 16 | Sequences to take: 1 = single mode, 0 = endless |
| tmo_limit | input | 16 | Stall cycles before timeout, 0 = off |
| irq_en | input | 3 | Enables: bit0 complete, bit1 overflow, bit2 timeout |
| irq_clr | input | 1 | Clears the interrupt line |
| stat_clr | input | 1 | Clears all status bits |
| conv_valid | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result |
| rd_en | input | 1 | Buffer read request |
| cap_strobe | output | 1 | One-cycle pulse per accepted sample |
| rd_data | output | 12 | Buffer read data |
| rd_empty | output | 1 | Buffer empty |
| busy | output | 1 | Armed or capturing |
| all_done | output | 1 | Final sequence of a finite total finished |
| irq | output | 1 | Interrupt line |
| irq_stat | output | 3 | Latched status: bit0 complete, bit1 overflow, bit2 timeout |

## Verification
The bench sweeps samples per sequence from 1 to 4 against totals of 1 to 3. It counts and checks every buffered word, so a sequencer that is off by one on the sample or sequence count, or that accepts data while waiting for a trigger, shows a wrong word count. It drives the overflow edge of a full buffer. A wrong drop length shows up as lost or surplus words after recovery. It also brackets the timeout limit from both sides. An abort in mid-sequence followed by a restart exposes counters that survive the abort, because the restarted sequence then ends early. Separate clear pulses catch an interrupt line and status bits that are wrongly tied together.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CAP, ST_DONE} seq_state_e;
  localparam int unsigned EV_DONE = 0;
  localparam int unsigned EV_OVF  = 1;
  localparam int unsigned EV_TMO  = 2;
  localparam int unsigned EV_N    = 3;
endpackage

// File: rtl/adcseq_ctrl.sv
`timescale 1ns/1ps
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          trig,
  input  logic          conv_valid,
  input  logic          buf_full,
  input  logic [CW-1:0] cfg_smp,
  input  logic [CW-1:0] cfg_seq,
  input  logic [TW-1:0] cfg_tmo,
  output logic          take,
  output logic          ev_done,
  output logic          ev_tmo,
  output logic          busy,
  output logic          done
);
  seq_state_e    state_q;
  logic [CW-1:0] smp_idx_q;
  logic [CW-1:0] seq_idx_q;
  logic [TW-1:0] tmo_q;
  logic          smp_last;
  logic          seq_last;
  logic          stall;

  // sample acceptance and end-of-sequence detection (R2, R3)
  assign take     = run_en && (state_q == ST_CAP) && conv_valid;
  assign smp_last = (cfg_smp != '0) && (smp_idx_q == cfg_smp - CW'(1));
  assign seq_last = (cfg_seq != '0) && (seq_idx_q == cfg_seq - CW'(1));
  assign ev_done  = take && smp_last;

  // sequencing: single mode is simply a total of one (R1, R4, R5, R10)
  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      state_q   <= ST_IDLE;
      smp_idx_q <= '0;
      seq_idx_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (trig) begin
            state_q   <= ST_CAP;
            smp_idx_q <= '0;
          end
        end
        ST_CAP: begin
          if (take) begin
            if (smp_last) begin
              smp_idx_q <= '0;
              seq_idx_q <= seq_idx_q + CW'(1);
              state_q   <= seq_last ? ST_DONE : ST_WAIT;
            end else begin
              smp_idx_q <= smp_idx_q + CW'(1);
            end
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  // stall timer (R8): saturates at the limit so the event fires once per stall
  assign stall  = run_en && ((state_q == ST_WAIT) || ((state_q == ST_CAP) && buf_full));
  assign ev_tmo = stall && (cfg_tmo != '0) && (tmo_q == cfg_tmo - TW'(1));

  always_ff @(posedge clk) begin
    if (rst || !stall) begin
      tmo_q <= '0;
    end else if (tmo_q != cfg_tmo) begin
      tmo_q <= tmo_q + TW'(1);
    end
  end

  assign busy = (state_q == ST_WAIT) || (state_q == ST_CAP);
  assign done = (state_q == ST_DONE);
endmodule

// File: rtl/adcseq_fifo.sv
`timescale 1ns/1ps
module adcseq_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 16,
  parameter int DROP  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          ev_ovf
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW   = $clog2(DEPTH + 1);
  localparam int DCW  = $clog2(DROP + 1);

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp_q;
  logic [AW-1:0]  rp_q;
  logic [NW-1:0]  cnt_q;
  logic [DCW-1:0] drop_q;
  logic [DW-1:0]  rd_q;
  logic           full;
  logic           wr_fire;
  logic           rd_fire;

  assign full    = (cnt_q == NW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_fire = wr_req && !full && (drop_q == '0);
  assign rd_fire = rd_en && !empty;
  // overflow starts a discard block that includes the offending word (R7)
  assign ev_ovf  = wr_req && full && (drop_q == '0);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp_q] <= wr_data;
    if (rd_fire) rd_q <= mem[rp_q];
  end
  assign rd_data = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      drop_q <= '0;
    end else begin
      if (wr_fire) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (rd_fire) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      case ({wr_fire, rd_fire})
        2'b10:   cnt_q <= cnt_q + NW'(1);
        2'b01:   cnt_q <= cnt_q - NW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (ev_ovf) begin
        drop_q <= DCW'(DROP - 1);
      end else if (wr_req && (drop_q != '0)) begin
        drop_q <= drop_q - DCW'(1);
      end
    end
  end
endmodule

// File: rtl/adcseq_irq.sv
`timescale 1ns/1ps
module adcseq_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] ien,
  input  logic         clr_irq,
  input  logic         clr_stat,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic irq_q;

  // one latched status bit per source; a new event wins over a clear (R6, R9)
  for (genvar g = 0; g < N; g++) begin : g_src
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= (bit_q && !clr_stat) || ev[g];
    end
    assign stat[g] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (irq_q && !clr_irq) || (|(ev & ien));
  end
  assign irq = irq_q;
endmodule

// File: rtl/adc_seq_capture.sv
`timescale 1ns/1ps
module adc_seq_capture
  import adcseq_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 16,
  parameter int TW    = 16,
  parameter int DEPTH = 16,
  parameter int DROP  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic            trig,
  input  logic [CW-1:0]   smp_per_seq,
  input  logic [CW-1:0]   seq_total,
  input  logic [TW-1:0]   tmo_limit,
  input  logic [EV_N-1:0] irq_en,
  input  logic            irq_clr,
  input  logic            stat_clr,
  input  logic            conv_valid,
  input  logic [DW-1:0]   conv_data,
  input  logic            rd_en,
  output logic            cap_strobe,
  output logic [DW-1:0]   rd_data,
  output logic            rd_empty,
  output logic            busy,
  output logic            all_done,
  output logic            irq,
  output logic [EV_N-1:0] irq_stat
);
  logic            take;
  logic            ev_done;
  logic            ev_tmo;
  logic            ev_ovf;
  logic            buf_full_n;
  logic [EV_N-1:0] ev_vec;
  logic            strobe_q;

  adcseq_ctrl #(.CW(CW), .TW(TW)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .trig       (trig),
    .conv_valid (conv_valid),
    .buf_full   (!buf_full_n),
    .cfg_smp    (smp_per_seq),
    .cfg_seq    (seq_total),
    .cfg_tmo    (tmo_limit),
    .take       (take),
    .ev_done    (ev_done),
    .ev_tmo     (ev_tmo),
    .busy       (busy),
    .done       (all_done)
  );

  adcseq_fifo #(.DW(DW), .DEPTH(DEPTH), .DROP(DROP)) fifo_i (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (take),
    .wr_data (conv_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (rd_empty),
    .ev_ovf  (ev_ovf)
  );

  // the controller only needs to know whether a write would fail
  adcseq_room #(.DW(DW), .DEPTH(DEPTH)) room_i (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (take),
    .rd_fire (rd_en && !rd_empty),
    .ovf     (ev_ovf),
    .has_room(buf_full_n)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[EV_DONE] = ev_done;
    ev_vec[EV_OVF]  = ev_ovf;
    ev_vec[EV_TMO]  = ev_tmo;
  end

  adcseq_irq #(.N(EV_N)) irq_i (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_vec),
    .ien      (irq_en),
    .clr_irq  (irq_clr),
    .clr_stat (stat_clr),
    .stat     (irq_stat),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= take;
  end
  assign cap_strobe = strobe_q;
endmodule

module adcseq_room #(
  parameter int DW    = 12,
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_fire,
  input  logic rd_fire,
  input  logic ovf,
  output logic has_room
);
  localparam int NW = $clog2(DEPTH + 1);
  logic [NW-1:0] lvl_q;
  logic          stored;

  // mirrors the fill level for the stall timer; discarded words never land
  assign stored   = wr_fire && (lvl_q != NW'(DEPTH)) && !ovf && !drop_active;
  assign has_room = (lvl_q != NW'(DEPTH));

  logic [$clog2(DW + 17)-1:0] drop_q;
  logic drop_active;
  assign drop_active = (drop_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      drop_q <= '0;
    end else begin
      case ({stored, rd_fire})
        2'b10:   lvl_q <= lvl_q + NW'(1);
        2'b01:   lvl_q <= lvl_q - NW'(1);
        default: lvl_q <= lvl_q;
      endcase
      if (ovf)                         drop_q <= 5'd15;
      else if (wr_fire && drop_active) drop_q <= drop_q - 1'b1;
    end
  end
endmodule

module adcseq_chk #(
  parameter int CW = 16,
  parameter int N  = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          run_en,
  input logic          conv_valid,
  input logic          cap_strobe,
  input logic          busy,
  input logic          all_done,
  input logic          irq,
  input logic [N-1:0]  irq_en,
  input logic [N-1:0]  irq_stat,
  input logic [CW-1:0] smp_per_seq,
  input logic [CW-1:0] seq_total
);
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!busy && !all_done));
  a_r2_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    cap_strobe |-> $past(run_en && conv_valid && busy));
  a_r6_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (|($past(irq_en) & irq_stat)));
  a_r3_no_done_endless: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_stat[0]) |-> ($past(smp_per_seq) != '0));
  a_r5_no_final_endless: assert property (@(posedge clk) disable iff (rst)
    $rose(all_done) |-> ($past(seq_total) != '0));
  a_r7_ovf_on_write: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_stat[1]) |-> $past(run_en && conv_valid));
endmodule

bind adc_seq_capture adcseq_chk #(.CW(CW), .N(adcseq_pkg::EV_N)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .run_en      (run_en),
  .conv_valid  (conv_valid),
  .cap_strobe  (cap_strobe),
  .busy        (busy),
  .all_done    (all_done),
  .irq         (irq),
  .irq_en      (irq_en),
  .irq_stat    (irq_stat),
  .smp_per_seq (smp_per_seq),
  .seq_total   (seq_total)
);

// File: tb/adc_seq_capture_tb.sv
`timescale 1ns/1ps
module adc_seq_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        trig = 1'b0;
  logic [15:0] smp_per_seq = '0;
  logic [15:0] seq_total = '0;
  logic [15:0] tmo_limit = '0;
  logic [2:0]  irq_en = '0;
  logic        irq_clr = 1'b0;
  logic        stat_clr = 1'b0;
  logic        conv_valid = 1'b0;
  logic [11:0] conv_data = '0;
  logic        rd_en = 1'b0;
  logic        cap_strobe;
  logic [11:0] rd_data;
  logic        rd_empty;
  logic        busy;
  logic        all_done;
  logic        irq;
  logic [2:0]  irq_stat;

  int vectors = 0;
  int fails = 0;
  int nstb = 0;

  always #10 clk = ~clk;

  adc_seq_capture dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .trig(trig),
    .smp_per_seq(smp_per_seq), .seq_total(seq_total), .tmo_limit(tmo_limit),
    .irq_en(irq_en), .irq_clr(irq_clr), .stat_clr(stat_clr),
    .conv_valid(conv_valid), .conv_data(conv_data), .rd_en(rd_en),
    .cap_strobe(cap_strobe), .rd_data(rd_data), .rd_empty(rd_empty),
    .busy(busy), .all_done(all_done), .irq(irq), .irq_stat(irq_stat)
  );

  always @(negedge clk) if (cap_strobe) nstb++;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic pulse_stat_clr();
    @(negedge clk) stat_clr = 1'b1;
    @(negedge clk) stat_clr = 1'b0;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  task automatic feed(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      conv_valid = 1'b1;
      conv_data  = 12'((base + i) & 12'hFFF);
    end
    @(negedge clk) conv_valid = 1'b0;
    @(negedge clk);
  endtask

  // R11: words come back in order, one cycle after each read
  task automatic drain(input string tag, input int base, input int exp_n);
    int n = 0;
    while (!rd_empty && n < 40) begin
      rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
      chk({tag, " R11 data"}, int'(rd_data), (base + n) & 12'hFFF);
      n++;
    end
    chk({tag, " word count"}, n, exp_n);
  endtask

  task automatic restart(input int smp, input int seq);
    @(negedge clk) run_en = 1'b0;
    smp_per_seq = 16'(smp);
    seq_total   = 16'(seq);
    @(negedge clk) run_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 irq", int'(irq), 0);
    chk("R12 stat", int'(irq_stat), 0);
    chk("R12 busy", int'(busy), 0);
    chk("R12 done", int'(all_done), 0);
    chk("R12 strobe", int'(cap_strobe), 0);
    chk("R12 empty", int'(rd_empty), 1);

    // sweep: R1 single mode, R2 count per sequence, R4 loop re-arm
    for (int smp = 1; smp <= 4; smp++) begin
      for (int seq = 1; seq <= 3; seq++) begin
        restart(smp, seq);
        pulse_stat_clr();
        for (int s = 0; s < seq; s++) begin
          int st0;
          int base;
          base = 64 * seq + 16 * s + smp;
          feed(2, 12'h800);             // before trigger: ignored (R4)
          chk("R4 ignored while armed", int'(rd_empty), 1);
          pulse_trig();
          st0 = nstb;
          feed(smp + 2, base);          // surplus beyond the count is ignored
          chk("R2 strobes", nstb - st0, smp);
          drain("R2", base, smp);
          chk("R6 complete status", int'(irq_stat[0]), 1);
          pulse_stat_clr();
          chk("R4 done flag", int'(all_done), (s == seq - 1) ? 1 : 0);
        end
        pulse_trig();
        feed(3, 12'h700);
        chk("R1 no capture after final", int'(rd_empty), 1);
        chk("R1 idle after final", int'(busy), 0);
      end
    end

    // R5 endless sequences
    restart(3, 0);
    for (int s = 0; s < 6; s++) begin
      pulse_trig();
      feed(3, 40 * s);
      drain("R5", 40 * s, 3);
    end
    chk("R5 never done", int'(all_done), 0);
    chk("R5 still busy", int'(busy), 1);

    // R3 endless samples
    restart(0, 1);
    pulse_stat_clr();
    pulse_trig();
    feed(10, 12'h100);
    drain("R3 a", 12'h100, 10);
    feed(10, 12'h120);
    drain("R3 b", 12'h120, 10);
    chk("R3 no complete", int'(irq_stat[0]), 0);
    chk("R3 busy", int'(busy), 1);
    @(negedge clk) run_en = 1'b0;
    @(negedge clk);
    chk("R10 idle on drop", int'(busy), 0);

    // R7 overflow with a 16-word discard block
    irq_en = 3'b010;
    restart(0, 0);
    pulse_stat_clr();
    pulse_irq_clr();
    pulse_trig();
    feed(16, 12'h200);
    chk("R7 no ovf when just full", int'(irq_stat[1]), 0);
    feed(1, 12'h300);
    chk("R7 ovf status", int'(irq_stat[1]), 1);
    chk("R7 ovf irq", int'(irq), 1);
    drain("R7 kept", 12'h200, 16);
    feed(15, 12'h400);
    chk("R7 discarded", int'(rd_empty), 1);
    feed(3, 12'h500);
    drain("R7 resumed", 12'h500, 3);

    // R9 separate clears
    pulse_irq_clr();
    chk("R9 irq cleared", int'(irq), 0);
    chk("R9 stat kept", int'(irq_stat[1]), 1);
    pulse_stat_clr();
    chk("R9 stat cleared", int'(irq_stat), 0);

    // R6 masking: status without interrupt, then with
    irq_en = 3'b000;
    restart(2, 1);
    pulse_trig();
    feed(2, 12'h10);
    drain("R6 masked", 12'h10, 2);
    chk("R6 polled status", int'(irq_stat[0]), 1);
    chk("R6 masked irq", int'(irq), 0);
    pulse_stat_clr();
    irq_en = 3'b001;
    restart(2, 1);
    pulse_trig();
    feed(2, 12'h20);
    drain("R6 enabled", 12'h20, 2);
    chk("R6 irq raised", int'(irq), 1);
    pulse_irq_clr();
    pulse_stat_clr();

    // R8 timeout bracket and disable
    irq_en = 3'b100;
    tmo_limit = 16'd10;
    restart(2, 1);
    pulse_stat_clr();
    idle(4);
    chk("R8 before limit", int'(irq_stat[2]), 0);
    idle(10);
    chk("R8 after limit", int'(irq_stat[2]), 1);
    chk("R8 irq", int'(irq), 1);
    pulse_irq_clr();
    tmo_limit = 16'd0;
    restart(2, 1);
    pulse_stat_clr();
    idle(40);
    chk("R8 disabled", int'(irq_stat[2]), 0);

    // R10 abort resets counters
    restart(10, 1);
    pulse_trig();
    feed(3, 12'h30);
    @(negedge clk) run_en = 1'b0;
    @(negedge clk);
    chk("R10 abort busy", int'(busy), 0);
    drain("R10 partial", 12'h30, 3);
    @(negedge clk) run_en = 1'b1;
    @(negedge clk);
    pulse_trig();
    feed(7, 12'h40);
    chk("R10 not done early", int'(all_done), 0);
    feed(3, 12'h47);
    chk("R10 done after full count", int'(all_done), 1);
    drain("R10 full", 12'h40, 10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule